// File: doc/BRIEF.md
# Transposing Scan Address Generator

This block produces the framebuffer read address for each output pixel of a video readout path. It can walk the stored image in either of two orders. In row order the address rises by one for every pixel. In column order it rises by one full scanline stride per pixel, so each output line is one stored column. A panel whose native scan runs along the short edge can then show a landscape image straight from an unrotated buffer, with no rotation stage between the two.

A one-cycle frame-start pulse loads the scan order, the stored image width `W` and the stored height `H`, and starts the walk at address 0. One address is produced per clock while `rd_valid` is high. In column order, the address at the top of each new column is the column index, which a separate column counter supplies. No multiplier is used. After the `W*H`-th address the output goes idle until the next frame start. Pixel fetch, pixel formatting and sync timing belong to neighbouring blocks.

Top module: `transpose_scan_agen`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `rd_valid` is 0 and `rd_addr` is 0.
- R2: A `frame_start` pulse with nonzero `width` and `height` makes `rd_valid` 1 and `rd_addr` 0 in the following cycle.
- R3: With `scan_cols` = 0 (row order), the k-th valid address of a frame (k from 0) equals `(k / W) * W + (k % W)`, which is `k`. Each valid address is the previous one plus 1.
- R4: With `scan_cols` = 1 (column order), the k-th valid address is `(k % H) * W + (k / H)`. Inside a column, each address is the previous one plus `W`.
- R5: In column order, the address that follows the last pixel of column c is `c + 1`.
- R6: Exactly `W*H` consecutive cycles of a frame have `rd_valid` = 1. After them `rd_valid` stays 0 until the next `frame_start`, and every valid address is below `W*H`.
- R7: `scan_cols`, `width` and `height` are sampled only in the cycle `frame_start` is high. Changing them during a frame does not alter that frame's addresses.
- R8: A `frame_start` during an active frame abandons it. The next cycle restarts at address 0 under the newly sampled settings.
- R9: A `frame_start` with `width` = 0 or `height` = 0 produces no valid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse that loads settings and begins a frame |
| scan_cols | input | 1 | Scan order: 0 row order, 1 column (transposed) order |
| width | input | DIM_W | Stored image width W in pixels (scanline stride) |
| height | input | DIM_W | Stored image height H in scanlines |
| rd_addr | output | ADDR_W | Framebuffer read address for the current pixel |
| rd_valid | output | 1 | High while `rd_addr` names a pixel of the current frame |

## Verification
The properties assume that `frame_start` is the only point at which settings are taken in. They check step sizes against the latched width, not the live port. They also assume that an address following a pixel with no frame start belongs to the same frame. The stimulus drives the settings and the pulse only between clock edges. It deliberately disturbs the settings in mid-frame, so the latched-versus-live distinction is exercised rather than avoided. Sizes include square, wide, tall, single-row, single-column and zero-sized images, so the column wrap is reached at every column of non-square layouts.

// File: rtl/scan_agen_pkg.sv
package scan_agen_pkg;

    localparam int SCAN_DIM_W  = 5;
    localparam int SCAN_ADDR_W = 2 * SCAN_DIM_W;

    typedef enum logic {
        ORDER_ROWS = 1'b0,
        ORDER_COLS = 1'b1
    } scan_order_e;

    typedef struct packed {
        scan_order_e           order;
        logic [SCAN_DIM_W-1:0] w;
        logic [SCAN_DIM_W-1:0] h;
    } scan_cfg_t;

    function automatic logic cfg_nonempty(input logic [SCAN_DIM_W-1:0] w,
                                          input logic [SCAN_DIM_W-1:0] h);
        return (w != '0) && (h != '0);
    endfunction

    // Count of pixels walked before the slow counter moves.
    function automatic logic [SCAN_DIM_W-1:0] inner_span(input scan_cfg_t c);
        return (c.order == ORDER_COLS) ? c.h : c.w;
    endfunction

    function automatic logic [SCAN_DIM_W-1:0] outer_span(input scan_cfg_t c);
        return (c.order == ORDER_COLS) ? c.w : c.h;
    endfunction

endpackage

// File: rtl/scan_cfg_reg.sv
module scan_cfg_reg
    import scan_agen_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  scan_cfg_t cfg_in,
    output scan_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q <= cfg_in;
        end
    end
endmodule

// File: rtl/scan_wrap_counter.sv
module scan_wrap_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    input  logic [CNT_W-1:0] span,
    output logic [CNT_W-1:0] count,
    output logic             at_end
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign at_end = (count == span - ONE);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (advance) begin
            count <= at_end ? '0 : count + ONE;
        end
    end
endmodule

// File: rtl/scan_addr_step.sv
module scan_addr_step
    import scan_agen_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   advance,
    input  logic                   inner_wrap,
    input  scan_cfg_t              cfg,
    input  logic [SCAN_DIM_W-1:0]  outer_idx,
    output logic [SCAN_ADDR_W-1:0] addr
);
    localparam logic [SCAN_ADDR_W-1:0] UNIT = SCAN_ADDR_W'(1);

    logic [SCAN_ADDR_W-1:0] addr_next;

    always_comb begin
        addr_next = addr;
        if (cfg.order == ORDER_ROWS) begin
            addr_next = addr + UNIT;
        end else if (inner_wrap) begin
            addr_next = SCAN_ADDR_W'(outer_idx) + UNIT;
        end else begin
            addr_next = addr + SCAN_ADDR_W'(cfg.w);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            addr <= '0;
        end else if (advance) begin
            addr <= addr_next;
        end
    end
endmodule

// File: rtl/transpose_scan_agen.sv
module transpose_scan_agen
    import scan_agen_pkg::*;
#(
    parameter int DIM_W  = SCAN_DIM_W,
    parameter int ADDR_W = SCAN_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              scan_cols,
    input  logic [DIM_W-1:0]  width,
    input  logic [DIM_W-1:0]  height,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid
);
    scan_cfg_t cfg_in, cfg_q;
    logic [SCAN_DIM_W-1:0] in_cnt, out_cnt;
    logic in_end, out_end, active_q, last_pix;
    logic [SCAN_ADDR_W-1:0] addr_q;

    assign cfg_in.order = scan_cols ? ORDER_COLS : ORDER_ROWS;
    assign cfg_in.w     = SCAN_DIM_W'(width);
    assign cfg_in.h     = SCAN_DIM_W'(height);

    scan_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (frame_start),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    scan_wrap_counter #(.CNT_W(SCAN_DIM_W)) u_inner (
        .clk     (clk),
        .rst     (rst),
        .clear   (frame_start),
        .advance (active_q),
        .span    (inner_span(cfg_q)),
        .count   (in_cnt),
        .at_end  (in_end)
    );

    scan_wrap_counter #(.CNT_W(SCAN_DIM_W)) u_outer (
        .clk     (clk),
        .rst     (rst),
        .clear   (frame_start),
        .advance (active_q && in_end),
        .span    (outer_span(cfg_q)),
        .count   (out_cnt),
        .at_end  (out_end)
    );

    assign last_pix = active_q && in_end && out_end;

    scan_addr_step u_addr (
        .clk        (clk),
        .rst        (rst),
        .start      (frame_start),
        .advance    (active_q && !last_pix),
        .inner_wrap (in_end),
        .cfg        (cfg_q),
        .outer_idx  (out_cnt),
        .addr       (addr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
        end else if (frame_start) begin
            active_q <= cfg_nonempty(cfg_in.w, cfg_in.h);
        end else if (last_pix) begin
            active_q <= 1'b0;
        end
    end

    assign rd_addr  = ADDR_W'(addr_q);
    assign rd_valid = active_q;

    logic unused_ok;
    assign unused_ok = ^in_cnt;
endmodule

// File: rtl/scan_agen_checker.sv
module scan_agen_checker #(
    parameter int DIM_W  = 5,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_start,
    input logic              scan_cols,
    input logic [DIM_W-1:0]  width,
    input logic [DIM_W-1:0]  height,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_valid
);
    logic             ck_cols;
    logic [DIM_W-1:0] ck_w, ck_h;
    logic [ADDR_W-1:0] ck_total;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_cols <= 1'b0;
            ck_w    <= '0;
            ck_h    <= '0;
        end else if (frame_start) begin
            ck_cols <= scan_cols;
            ck_w    <= width;
            ck_h    <= height;
        end
    end

    assign ck_total = ADDR_W'(ck_w) * ADDR_W'(ck_h);

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!rd_valid && rd_addr == '0));

    a_r2_start_at_zero: assert property (@(posedge clk) disable iff (rst)
        (frame_start && width != '0 && height != '0) |=> (rd_valid && rd_addr == '0));

    a_r3_row_step: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !frame_start && !ck_cols) |=>
            (!rd_valid || rd_addr == $past(rd_addr) + ADDR_W'(1)));

    a_r4_col_step: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !frame_start && ck_cols) |=>
            (!rd_valid || rd_addr == $past(rd_addr) + ADDR_W'(ck_w)
                       || rd_addr < ADDR_W'(ck_w)));

    a_r6_in_range: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_addr < ck_total));

    a_r6_stays_idle: assert property (@(posedge clk) disable iff (rst)
        (!rd_valid && !frame_start) |=> !rd_valid);

    a_r9_empty_frame: assert property (@(posedge clk) disable iff (rst)
        (frame_start && (width == '0 || height == '0)) |=> !rd_valid);
endmodule

bind transpose_scan_agen scan_agen_checker #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .scan_cols   (scan_cols),
    .width       (width),
    .height      (height),
    .rd_addr     (rd_addr),
    .rd_valid    (rd_valid)
);

// File: tb/transpose_scan_agen_bench.sv
module transpose_scan_agen_bench;
    localparam int DW = 5;
    localparam int AW = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_start = 1'b0;
    logic scan_cols = 1'b0;
    logic [DW-1:0] width = '0;
    logic [DW-1:0] height = '0;
    logic [AW-1:0] rd_addr;
    logic rd_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    transpose_scan_agen u_transpose_scan_agen (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .scan_cols   (scan_cols),
        .width       (width),
        .height      (height),
        .rd_addr     (rd_addr),
        .rd_valid    (rd_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge. disturb: scramble settings mid-frame (R7).
    // stop_at >= 0 abandons the frame after that many pixels (R8).
    task automatic run_frame(input bit cols, input int w, input int h,
                             input bit disturb, input int stop_at);
        int total = w * h;
        frame_start = 1'b1;
        scan_cols   = cols;
        width       = DW'(w);
        height      = DW'(h);
        @(negedge clk);
        frame_start = 1'b0;
        for (int k = 0; k < total; k++) begin
            int exp_addr;
            if (stop_at >= 0 && k == stop_at) return;
            if (cols) exp_addr = (k % h) * w + (k / h);
            else      exp_addr = (k / w) * w + (k % w);
            if (k == 0)
                check("R2 first pixel valid", int'(rd_valid), 1);
            else
                check(cols ? "R6 valid run (cols)" : "R6 valid run (rows)", int'(rd_valid), 1);
            if (k == 0)
                check("R2 first address", int'(rd_addr), 0);
            else if (disturb)
                check("R7 settings held", int'(rd_addr), exp_addr);
            else if (cols && (k % h) == 0)
                check("R5 column wrap", int'(rd_addr), exp_addr);
            else if (cols)
                check("R4 column order", int'(rd_addr), exp_addr);
            else
                check("R3 row order", int'(rd_addr), exp_addr);
            if (disturb && k == total / 2) begin
                scan_cols = ~cols;
                width     = DW'(w + 3);
                height    = DW'(h + 2);
            end
            @(negedge clk);
        end
        for (int i = 0; i < 3; i++) begin
            check("R6 idle after last pixel", int'(rd_valid), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        @(negedge clk);
        check("R1 reset valid", int'(rd_valid), 0);
        check("R1 reset addr", int'(rd_addr), 0);
        @(negedge clk);
        rst = 1'b0;
        check("R1 after reset valid", int'(rd_valid), 0);
        check("R1 after reset addr", int'(rd_addr), 0);
        repeat (2) @(negedge clk);

        for (int c = 0; c < 2; c++) begin
            run_frame(c[0], 8, 8, 1'b0, -1);
            run_frame(c[0], 5, 3, 1'b0, -1);
            run_frame(c[0], 3, 5, 1'b0, -1);
            run_frame(c[0], 1, 1, 1'b0, -1);
            run_frame(c[0], 1, 7, 1'b0, -1);
            run_frame(c[0], 7, 1, 1'b0, -1);
            run_frame(c[0], 31, 2, 1'b0, -1);
            run_frame(c[0], 2, 31, 1'b0, -1);
            run_frame(c[0], 31, 31, 1'b0, -1);
        end

        // R7: settings changed mid-frame are ignored
        run_frame(1'b1, 6, 4, 1'b1, -1);
        run_frame(1'b0, 6, 4, 1'b1, -1);

        // R8: restart mid-frame in the other order and size
        run_frame(1'b0, 9, 9, 1'b0, 13);
        check("R8 restart pending", int'(rd_valid), 1);
        run_frame(1'b1, 4, 6, 1'b0, -1);
        run_frame(1'b1, 7, 5, 1'b0, 20);
        run_frame(1'b0, 5, 7, 1'b0, -1);

        // R9: empty frames
        for (int z = 0; z < 2; z++) begin
            frame_start = 1'b1;
            scan_cols   = z[0];
            width       = (z == 0) ? DW'(0) : DW'(4);
            height      = (z == 0) ? DW'(4) : DW'(0);
            @(negedge clk);
            frame_start = 1'b0;
            for (int i = 0; i < 4; i++) begin
                check("R9 empty frame idle", int'(rd_valid), 0);
                @(negedge clk);
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule